// File: doc/BRIEF.md
# Console Mailbox Front-End Controller

This block links a host processor's console to a character terminal. The two sides share three words in memory: an output mailbox, an input mailbox and a switch word. There is one interrupt line in each direction. To print, the host writes a character with its valid flag into the output mailbox and then pulses the attention input. The controller reads the mailbox and hands the character to a byte-stream transmitter. Once the transmitter has taken the character, the controller zeroes the mailbox and raises the host interrupt.

In the other direction, the controller polls a receive byte stream. It polls on a fixed period, and also at once when an attention pulse finds no output work pending. A received character goes into the input mailbox with the valid flag set, and the same host interrupt line is raised. The host never confirms that it has taken an input character. For that reason the controller reads the input mailbox before every poll and accepts a new byte only when the host has cleared the valid flag.

A stop request writes a fixed code into the switch word. Two running counters report how many characters have gone out and how many have come in.

Top module: `cty_mailbox_ctrl`

## Requirements
- R1: After reset the controller writes zero to the output mailbox and then to the input mailbox. The host interrupt is low, the transmit stream is idle and both character counts are zero.
- R2: When an attention pulse finds bit 8 (valid) set in the output mailbox word, the transmit stream carries bits 6:0 of that word. Every other bit is dropped.
- R3: While the transmitter holds ready low, the character stays on the stream unchanged and valid. The output mailbox is not written and no interrupt is raised.
- R4: After the transmit handshake, the controller writes an all-zero word to the output mailbox, raises the host interrupt and increments the output count by one.
- R5: An attention pulse that finds the output valid flag clear and the input valid flag clear polls the receive stream immediately. A received byte is written to the input mailbox as bits 6:0 of the byte plus bit 8 set, with all other bits zero. The host interrupt is raised and the input count increments.
- R6: While bit 8 of the input mailbox is set, no receive byte is accepted and the input mailbox is not written.
- R7: A byte received with the break flag set is consumed from the stream. It produces no mailbox write, no interrupt and no count change.
- R8: The host interrupt is a level. Once raised it stays high until a clear pulse. A new event in the same cycle as a clear leaves it high.
- R9: A stop pulse writes the parameter STOP_CODE into the switch word.
- R10: Without any attention pulse, the controller polls the receive stream every POLL_CYC cycles.
- R11: When an attention pulse finds a valid output character, output is served first. No receive byte is accepted before the output completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attn_i | input | 1 | Single-cycle attention pulse from the host |
| stop_req_i | input | 1 | Single-cycle stop request |
| irq_clr_i | input | 1 | Host acknowledge; clears the interrupt level |
| irq_o | output | 1 | Interrupt level to the host |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | 36 | Write data |
| mem_rdata_i | input | 36 | Read data, valid the cycle after a read strobe |
| tx_valid_o | output | 1 | Transmit character valid |
| tx_data_o | output | 7 | Transmit character |
| tx_ready_i | input | 1 | Transmitter accepts the character |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_break_i | input | 1 | Receive byte is a break condition |
| rx_ready_o | output | 1 | Controller takes the receive byte |
| tx_count_o | output | CNT_W | Characters transmitted |
| rx_count_o | output | CNT_W | Characters deposited |

## Verification
The assertions assume a memory that accepts every strobe and returns read data exactly one cycle later. They also assume that the host does not write the same mailbox in the cycle the controller writes it, and that the receive stream keeps a byte stable until it is taken. The bench memory model answers every read on the next edge. Host writes are issued only while the controller is idle or busy with the transmitter. Each receive byte is held until the cycle after its handshake.

// File: rtl/cty_mbx_pkg.sv
package cty_mbx_pkg;

    localparam int WORD_W  = 36;
    localparam int CHAR_W  = 7;
    localparam int BYTE_W  = 8;
    localparam int VLD_BIT = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CHAR_W-1:0] char_t;

    localparam word_t WORD_CHAR_MASK = word_t'((1 << CHAR_W) - 1);
    localparam logic [BYTE_W-1:0] BYTE_CHAR_MASK = BYTE_W'((1 << CHAR_W) - 1);

    typedef enum logic [3:0] {
        ST_INIT_OUT,
        ST_INIT_IN,
        ST_IDLE,
        ST_STOP_WR,
        ST_RD_OUT,
        ST_CHK_OUT,
        ST_TX,
        ST_CLR_OUT,
        ST_RD_IN,
        ST_CHK_IN,
        ST_POLL,
        ST_WR_IN
    } seq_state_e;

    typedef struct packed {
        logic  req;
        logic  we;
        word_t data;
    } mem_cmd_t;

    function automatic char_t word_to_char(input word_t w);
        return char_t'(w & WORD_CHAR_MASK);
    endfunction

    function automatic char_t byte_to_char(input logic [BYTE_W-1:0] b);
        return char_t'(b & BYTE_CHAR_MASK);
    endfunction

    function automatic logic word_valid(input word_t w);
        return w[VLD_BIT];
    endfunction

    function automatic word_t char_to_word(input char_t c);
        word_t w;
        w = '0;
        w[CHAR_W-1:0] = c;
        w[VLD_BIT] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/cty_evt_counter.sv
module cty_evt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    always_ff @(posedge clk) begin
        if (rst)        count_o <= '0;
        else if (inc_i) count_o <= count_o + 1'b1;
    end

endmodule

// File: rtl/cty_poll_timer.sv
module cty_poll_timer #(
    parameter int POLL_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);

    localparam int PW = (POLL_CYC > 2) ? $clog2(POLL_CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(POLL_CYC - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    generate
        if (POLL_CYC > 1) begin : g_spacing
            a_r10_tick_single: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/cty_irq_latch.sv
module cty_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    always_ff @(posedge clk) begin
        if (rst)        irq_o <= 1'b0;
        else if (set_i) irq_o <= 1'b1;
        else if (clr_i) irq_o <= 1'b0;
    end

    a_r8_level_held: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !clr_i) |=> irq_o);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> irq_o);

endmodule

// File: rtl/cty_mbx_seq.sv
module cty_mbx_seq
    import cty_mbx_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] OUT_ADDR  = 'h33,
    parameter logic [ADDR_W-1:0] IN_ADDR   = 'h32,
    parameter logic [ADDR_W-1:0] SW_ADDR   = 'h31,
    parameter word_t             STOP_CODE = 36'd3840
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              attn_i,
    input  logic              stop_i,
    input  logic              poll_tick_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output word_t             mem_wdata_o,
    input  word_t             mem_rdata_i,
    output logic              tx_valid_o,
    output char_t             tx_data_o,
    input  logic              tx_ready_i,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic              rx_break_i,
    output logic              rx_ready_o,
    output logic              irq_set_o,
    output logic              tx_done_o,
    output logic              rx_done_o
);

    seq_state_e state_q, state_d;
    logic attn_pend_q, stop_pend_q, poll_pend_q;
    logic take_attn, take_stop, take_poll;
    logic ld_tx, ld_rx;
    char_t tx_hold_q, rx_hold_q;
    mem_cmd_t cmd;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        state_d   = state_q;
        cmd       = '0;
        addr_d    = OUT_ADDR;
        tx_valid_o = 1'b0;
        rx_ready_o = 1'b0;
        irq_set_o = 1'b0;
        tx_done_o = 1'b0;
        rx_done_o = 1'b0;
        take_attn = 1'b0;
        take_stop = 1'b0;
        take_poll = 1'b0;
        ld_tx     = 1'b0;
        ld_rx     = 1'b0;
        unique case (state_q)
            ST_INIT_OUT: begin
                cmd = '{req: 1'b1, we: 1'b1, data: '0};
                addr_d = OUT_ADDR;
                state_d = ST_INIT_IN;
            end
            ST_INIT_IN: begin
                cmd = '{req: 1'b1, we: 1'b1, data: '0};
                addr_d = IN_ADDR;
                state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (stop_pend_q) begin
                    take_stop = 1'b1;
                    state_d = ST_STOP_WR;
                end else if (attn_pend_q) begin
                    take_attn = 1'b1;
                    state_d = ST_RD_OUT;
                end else if (poll_pend_q) begin
                    take_poll = 1'b1;
                    state_d = ST_RD_IN;
                end
            end
            ST_STOP_WR: begin
                cmd = '{req: 1'b1, we: 1'b1, data: STOP_CODE};
                addr_d = SW_ADDR;
                state_d = ST_IDLE;
            end
            ST_RD_OUT: begin
                cmd.req = 1'b1;
                addr_d = OUT_ADDR;
                state_d = ST_CHK_OUT;
            end
            ST_CHK_OUT: begin
                if (word_valid(mem_rdata_i)) begin
                    ld_tx = 1'b1;
                    state_d = ST_TX;
                end else begin
                    state_d = ST_RD_IN;
                end
            end
            ST_TX: begin
                tx_valid_o = 1'b1;
                if (tx_ready_i) begin
                    tx_done_o = 1'b1;
                    state_d = ST_CLR_OUT;
                end
            end
            ST_CLR_OUT: begin
                cmd = '{req: 1'b1, we: 1'b1, data: '0};
                addr_d = OUT_ADDR;
                irq_set_o = 1'b1;
                state_d = ST_IDLE;
            end
            ST_RD_IN: begin
                cmd.req = 1'b1;
                addr_d = IN_ADDR;
                state_d = ST_CHK_IN;
            end
            ST_CHK_IN: begin
                state_d = word_valid(mem_rdata_i) ? ST_IDLE : ST_POLL;
            end
            ST_POLL: begin
                rx_ready_o = 1'b1;
                if (rx_valid_i && !rx_break_i) begin
                    ld_rx = 1'b1;
                    state_d = ST_WR_IN;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR_IN: begin
                cmd = '{req: 1'b1, we: 1'b1, data: char_to_word(rx_hold_q)};
                addr_d = IN_ADDR;
                irq_set_o = 1'b1;
                rx_done_o = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_INIT_OUT;
            attn_pend_q <= 1'b0;
            stop_pend_q <= 1'b0;
            poll_pend_q <= 1'b0;
            tx_hold_q   <= '0;
            rx_hold_q   <= '0;
        end else begin
            state_q     <= state_d;
            attn_pend_q <= attn_i | (attn_pend_q & ~take_attn);
            stop_pend_q <= stop_i | (stop_pend_q & ~take_stop);
            poll_pend_q <= poll_tick_i | (poll_pend_q & ~take_poll);
            if (ld_tx) tx_hold_q <= word_to_char(mem_rdata_i);
            if (ld_rx) rx_hold_q <= byte_to_char(rx_data_i);
        end
    end

    assign mem_req_o   = cmd.req;
    assign mem_we_o    = cmd.we;
    assign mem_wdata_o = cmd.data;
    assign mem_addr_o  = addr_d;
    assign tx_data_o   = tx_hold_q;

    // R3: backpressure keeps the character
    a_r3_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

    a_r3_no_early_clear: assert property (@(posedge clk) disable iff (rst)
        tx_valid_o |-> !(mem_req_o && mem_we_o));

    a_r4_clear_after_accept: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && tx_ready_i) |=>
            (mem_req_o && mem_we_o && mem_addr_o == OUT_ADDR && mem_wdata_o == '0));

    a_r5_deposit_after_take: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_i && rx_ready_o && !rx_break_i) |=>
            (mem_req_o && mem_we_o && mem_addr_o == IN_ADDR && mem_wdata_o[VLD_BIT]));

    a_r5_in_word_shape: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o && mem_addr_o == IN_ADDR) |->
            (mem_wdata_o[WORD_W-1:VLD_BIT+1] == '0 && mem_wdata_o[VLD_BIT-1:CHAR_W] == '0));

    a_r6_poll_after_clear: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready_o) |->
            ($past(mem_rdata_i[VLD_BIT]) == 1'b0 &&
             $past(mem_req_o && !mem_we_o && mem_addr_o == IN_ADDR, 2)));

    a_r7_break_no_write: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_i && rx_ready_o && rx_break_i) |=> !(mem_req_o && mem_we_o) && !irq_set_o);

    a_r11_one_stream: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid_o && rx_ready_o));

endmodule

// File: rtl/cty_mailbox_ctrl.sv
module cty_mailbox_ctrl
    import cty_mbx_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] OUT_ADDR  = 'h33,
    parameter logic [ADDR_W-1:0] IN_ADDR   = 'h32,
    parameter logic [ADDR_W-1:0] SW_ADDR   = 'h31,
    parameter logic [35:0]       STOP_CODE = 36'd3840,
    parameter int                POLL_CYC  = 64,
    parameter int                CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              attn_i,
    input  logic              stop_req_i,
    input  logic              irq_clr_i,
    output logic              irq_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [35:0]       mem_wdata_o,
    input  logic [35:0]       mem_rdata_i,
    output logic              tx_valid_o,
    output logic [6:0]        tx_data_o,
    input  logic              tx_ready_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    input  logic              rx_break_i,
    output logic              rx_ready_o,
    output logic [CNT_W-1:0]  tx_count_o,
    output logic [CNT_W-1:0]  rx_count_o
);

    localparam int N_CNT = 2;

    logic poll_tick;
    logic irq_set;
    logic tx_done, rx_done;
    logic [N_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_val [N_CNT];

    cty_poll_timer #(.POLL_CYC(POLL_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_o (poll_tick)
    );

    cty_mbx_seq #(
        .ADDR_W    (ADDR_W),
        .OUT_ADDR  (OUT_ADDR),
        .IN_ADDR   (IN_ADDR),
        .SW_ADDR   (SW_ADDR),
        .STOP_CODE (STOP_CODE)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .attn_i      (attn_i),
        .stop_i      (stop_req_i),
        .poll_tick_i (poll_tick),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .tx_valid_o  (tx_valid_o),
        .tx_data_o   (tx_data_o),
        .tx_ready_i  (tx_ready_i),
        .rx_valid_i  (rx_valid_i),
        .rx_data_i   (rx_data_i),
        .rx_break_i  (rx_break_i),
        .rx_ready_o  (rx_ready_o),
        .irq_set_o   (irq_set),
        .tx_done_o   (tx_done),
        .rx_done_o   (rx_done)
    );

    cty_irq_latch u_irq (
        .clk   (clk),
        .rst   (rst),
        .set_i (irq_set),
        .clr_i (irq_clr_i),
        .irq_o (irq_o)
    );

    assign cnt_inc = {rx_done, tx_done};

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        cty_evt_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .inc_i   (cnt_inc[g]),
            .count_o (cnt_val[g])
        );
    end

    assign tx_count_o = cnt_val[0];
    assign rx_count_o = cnt_val[1];

    // R1: reset state of the host-facing outputs
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!irq_o && !tx_valid_o && tx_count_o == '0 && rx_count_o == '0));

endmodule

// File: tb/test_cty_mailbox_ctrl.sv
`timescale 1ns/1ps
module test_cty_mailbox_ctrl;

    localparam logic [15:0] A_OUT = 16'h0033;
    localparam logic [15:0] A_IN  = 16'h0032;
    localparam logic [15:0] A_SW  = 16'h0031;
    localparam logic [35:0] STOP  = 36'd3840;
    localparam int          PCYC  = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic attn = 1'b0, stop_req = 1'b0, irq_clr = 1'b0;
    logic irq;
    logic mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [35:0] mem_wdata;
    logic [35:0] mem_rdata = '0;
    logic tx_valid, tx_ready = 1'b0;
    logic [6:0] tx_data;
    logic rx_valid = 1'b0, rx_break = 1'b0, rx_ready;
    logic [7:0] rx_data = '0;
    logic [15:0] tx_count, rx_count;

    logic host_we = 1'b0;
    logic [15:0] host_addr = '0;
    logic [35:0] host_data = '0;
    logic [35:0] m_out = 36'h0000_00ABC;
    logic [35:0] m_in  = 36'h0000_00DEF;
    logic [35:0] m_sw  = '0;
    int wr_out = 0, wr_in = 0, wr_sw = 0, rx_hs = 0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cty_mailbox_ctrl i_cty_mailbox_ctrl (
        .clk(clk), .rst(rst), .attn_i(attn), .stop_req_i(stop_req), .irq_clr_i(irq_clr),
        .irq_o(irq), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid),
        .tx_data_o(tx_data), .tx_ready_i(tx_ready), .rx_valid_i(rx_valid),
        .rx_data_i(rx_data), .rx_break_i(rx_break), .rx_ready_o(rx_ready),
        .tx_count_o(tx_count), .rx_count_o(rx_count)
    );

    // shared memory model: one-cycle read latency, controller writes win
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            if (mem_addr == A_OUT) begin m_out <= mem_wdata; wr_out <= wr_out + 1; end
            if (mem_addr == A_IN)  begin m_in  <= mem_wdata; wr_in  <= wr_in + 1;  end
            if (mem_addr == A_SW)  begin m_sw  <= mem_wdata; wr_sw  <= wr_sw + 1;  end
        end else if (host_we) begin
            if (host_addr == A_OUT) m_out <= host_data;
            if (host_addr == A_IN)  m_in  <= host_data;
        end
        if (mem_req && !mem_we)
            mem_rdata <= (mem_addr == A_OUT) ? m_out :
                         (mem_addr == A_IN)  ? m_in  :
                         (mem_addr == A_SW)  ? m_sw  : 36'h0;
        if (rx_valid && rx_ready) rx_hs <= rx_hs + 1;
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [15:0] a, input logic [35:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic pulse_attn();
        @(negedge clk); attn = 1'b1;
        @(negedge clk); attn = 1'b0;
    endtask

    task automatic wait_tx(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (tx_valid) begin ok = 1'b1; break; end
        end
    endtask

    task automatic tx_accept();
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
    endtask

    task automatic wait_irq(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (irq) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic clear_irq(input string tag);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check(tag, irq, 1'b0);
    endtask

    task automatic rx_take(input int max, output int lat);
        lat = -1;
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (rx_valid && rx_ready) begin
                lat = i;
                @(negedge clk);
                rx_valid = 1'b0; rx_break = 1'b0;
                break;
            end
        end
    endtask

    task automatic t_reset();
        check("R1 output mailbox zeroed", m_out, 36'h0);
        check("R1 input mailbox zeroed", m_in, 36'h0);
        check("R1 irq low", irq, 1'b0);
        check("R1 tx idle", tx_valid, 1'b0);
        check("R1 counts zero", {tx_count, rx_count}, 32'h0);
    endtask

    task automatic t_print();
        bit ok;
        host_write(A_OUT, 36'hF000001C1);
        pulse_attn();
        wait_tx(ok);
        check("R2 tx valid after attention", ok, 1'b1);
        check("R2 masked character", tx_data, 7'h41);
        tx_accept();
        wait_irq(ok);
        check("R4 irq raised", ok, 1'b1);
        check("R4 output mailbox cleared", m_out, 36'h0);
        check("R4 output count", tx_count, 16'd1);
        repeat (40) @(negedge clk);
        check("R8 irq level held", irq, 1'b1);
        clear_irq("R8 irq cleared by ack");
    endtask

    task automatic t_backpressure();
        bit ok;
        int bad = 0;
        host_write(A_OUT, 36'h155);
        pulse_attn();
        wait_tx(ok);
        check("R3 tx valid", ok, 1'b1);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!tx_valid || tx_data != 7'h55 || m_out != 36'h155 || irq) bad++;
        end
        check("R3 character held under backpressure", bad, 0);
        tx_accept();
        wait_irq(ok);
        check("R4 output mailbox cleared after stall", m_out, 36'h0);
        check("R4 output count after stall", tx_count, 16'd2);
        clear_irq("R8 ack after stalled output");
    endtask

    task automatic t_input_immediate();
        bit ok;
        int lat;
        @(negedge clk);
        rx_data = 8'hE3; rx_valid = 1'b1;
        attn = 1'b1;
        @(negedge clk); attn = 1'b0;
        rx_take(12, lat);
        check("R5 byte taken right after attention", lat >= 0, 1'b1);
        wait_irq(ok);
        check("R5 irq raised on input", ok, 1'b1);
        check("R5 input mailbox word", m_in, 36'h163);
        check("R5 input count", rx_count, 16'd1);
        clear_irq("R8 ack after input");
    endtask

    task automatic t_input_blocked();
        int w0, h0, lat;
        bit ok;
        w0 = wr_in; h0 = rx_hs;
        @(negedge clk);
        rx_data = 8'h2A; rx_valid = 1'b1;
        pulse_attn();
        repeat (2 * PCYC + 20) @(negedge clk);
        check("R6 no byte taken while valid set", rx_hs - h0, 0);
        check("R6 input mailbox untouched", wr_in - w0, 0);
        check("R6 no irq", irq, 1'b0);
        host_write(A_IN, 36'h0);
        rx_take(2 * PCYC + 20, lat);
        check("R10 periodic poll takes byte", lat >= 0, 1'b1);
        wait_irq(ok);
        check("R10 input mailbox word", m_in, 36'h12A);
        check("R10 input count", rx_count, 16'd2);
        clear_irq("R8 ack after periodic input");
        host_write(A_IN, 36'h0);
    endtask

    task automatic t_break();
        int w0, lat;
        w0 = wr_in;
        @(negedge clk);
        rx_data = 8'h41; rx_break = 1'b1; rx_valid = 1'b1;
        pulse_attn();
        rx_take(20, lat);
        check("R7 break consumed", lat >= 0, 1'b1);
        repeat (20) @(negedge clk);
        check("R7 no mailbox write", wr_in - w0, 0);
        check("R7 no irq", irq, 1'b0);
        check("R7 count unchanged", rx_count, 16'd2);
    endtask

    task automatic t_priority();
        bit ok;
        int h0, lat;
        h0 = rx_hs;
        host_write(A_OUT, 36'h14F);
        @(negedge clk);
        rx_data = 8'h31; rx_valid = 1'b1; attn = 1'b1;
        @(negedge clk); attn = 1'b0;
        wait_tx(ok);
        check("R11 output served", ok, 1'b1);
        check("R11 output character", tx_data, 7'h4F);
        repeat (5) @(negedge clk);
        tx_accept();
        wait_irq(ok);
        check("R11 no input before output done", rx_hs - h0, 0);
        check("R11 output mailbox cleared", m_out, 36'h0);
        clear_irq("R8 ack after priority output");
        rx_take(2 * PCYC + 20, lat);
        wait_irq(ok);
        check("R11 input served afterwards", m_in, 36'h131);
        clear_irq("R8 ack after deferred input");
        host_write(A_IN, 36'h0);
    endtask

    task automatic t_stop();
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        repeat (10) @(negedge clk);
        check("R9 switch word", m_sw, STOP);
        check("R9 single write", wr_sw, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        t_reset();
        t_print();
        t_backpressure();
        t_input_immediate();
        t_input_blocked();
        t_break();
        t_priority();
        t_stop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule